// File: doc/BRIEF.md
# Dual-Port Interrupting Mailbox Register File

This block is a small bank of byte-wide registers placed between a host processor and an embedded microcontroller. Each side reaches the bank through its own synchronous register bus, with an address, write data, a write strobe, a read strobe and registered read data. Most entries are plain shared scratch storage that either side may read or write. Two entries carry messages and raise an interrupt on the other side.

Entry 0 carries messages from the host to the controller. A host write there stores the byte and latches a pending event for the controller. A controller read of entry 0 retires that event. A controller write of any value to entry 0 zeroes it, and the host can see this as the acknowledgement. Entry 1 works the same way in the other direction. A controller write stores the byte and latches a pending system-management event for the host. A host read retires that event, and a host write of any value zeroes the entry. Each pending bit is sticky and is gated by its own enable input before it reaches the interrupt pin. Masking an interrupt therefore only hides an event and never discards it.

Top module: `mbox_regfile`

## Requirements
- R1: After a synchronous active-low reset, every entry holds 0x00, both read-data outputs are 0x00, and neither interrupt output is asserted.
- R2: A read strobe returns the addressed entry's contents on that port's read-data output in the following cycle. That value is the contents before any write made in the strobe cycle. Without a strobe, the read-data output holds its last value.
- R3: A host write to address 0 stores the byte and latches the controller pending event. The controller interrupt output equals the pending bit ANDed with the controller enable input.
- R4: A controller read of address 0 clears the controller pending event. If a host write to address 0 happens in the same cycle, the event stays pending.
- R5: A controller write of any value to address 0 sets that entry to 0x00 and leaves the pending event unchanged. If the host writes address 0 in the same cycle, the host's byte is stored.
- R6: A controller write to address 1 stores the byte and latches the host pending event. The host SMI output equals that pending bit ANDed with the host enable input.
- R7: A host read of address 1 clears the host pending event. If a controller write to address 1 happens in the same cycle, the event stays pending.
- R8: A host write of any value to address 1 sets that entry to 0x00 and leaves the pending event unchanged. If the controller writes address 1 in the same cycle, the controller's byte is stored.
- R9: While an enable input is low, its interrupt output is low but the pending event is kept. Raising the enable again asserts the output with no new write.
- R10: Addresses 2 to 31 are readable and writable from both ports. When both ports write the same such address in one cycle, the host byte is stored. Writes to different addresses in one cycle are both stored.
- R11: Reads and writes of any other address leave both pending events unchanged. Examples are a controller read of address 1 and a host read of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 5 | Host register index |
| h_wdata | input | 8 | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 8 | Host read data, one cycle after the strobe |
| c_addr | input | 5 | Controller offset from its mailbox base |
| c_wdata | input | 8 | Controller write data |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_rdata | output | 8 | Controller read data, one cycle after the strobe |
| c_irq_en | input | 1 | Enable for the controller interrupt |
| h_smi_en | input | 1 | Enable for the host system-management interrupt |
| c_irq | output | 1 | Level interrupt to the controller |
| h_smi | output | 1 | Level system-management interrupt to the host |

## Verification
The hardest situations to reach are the same-cycle collisions on the two message entries. In one, a sender's write lands in the same cycle as the receiver's clearing read. In the other, it lands in the same cycle as the receiver's acknowledging write. Both need the two ports to target address 0 or 1 in one exact cycle. The random stimulus draws most addresses from entries 0 to 2 and toggles the enables now and then, so these collisions occur many times. Directed sequences also force each collision once and read the result back through the ports.

// File: rtl/mbox_pkg.sv
// Package: shared constants and entry classification for the mailbox bank.
// Assumes both ports use the same index width.
package mbox_pkg;

    // Index of the host-to-controller message entry
    localparam int unsigned H2C_IDX = 0;
    // Index of the controller-to-host message entry
    localparam int unsigned C2H_IDX = 1;

    typedef enum logic [1:0] {
        ENTRY_H2C    = 2'd0,
        ENTRY_C2H    = 2'd1,
        ENTRY_SHARED = 2'd2
    } entry_kind_e;

    // Classify an entry index by its special behaviour
    function automatic entry_kind_e entry_kind(input int unsigned idx);
        if (idx == H2C_IDX)      return ENTRY_H2C;
        else if (idx == C2H_IDX) return ENTRY_C2H;
        else                     return ENTRY_SHARED;
    endfunction

endpackage

// File: rtl/mbox_store.sv
// Module: mbox_store
// Holds the register bank and resolves write collisions between the ports.
// The message entries take the sender's byte and are zeroed by a receiver
// write. The sender wins a collision. Shared entries take the host byte on a
// collision. Assumes the strobes are already qualified by the caller.
module mbox_store
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned AW         = $clog2(NUM_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                h_we,
    input  logic [AW-1:0]                       h_addr,
    input  logic [DATA_W-1:0]                   h_wdata,
    input  logic                                c_we,
    input  logic [AW-1:0]                       c_addr,
    input  logic [DATA_W-1:0]                   c_wdata,
    output logic [NUM_ENTRIES-1:0][DATA_W-1:0]  q
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        localparam entry_kind_e KIND = entry_kind(i);
        logic h_hit;
        logic c_hit;

        // Per-entry address decode for each port
        always_comb begin
            h_hit = h_we && (h_addr == AW'(i));
            c_hit = c_we && (c_addr == AW'(i));
        end

        if (KIND == ENTRY_H2C) begin : g_h2c
            // Host stores the message; a controller write acknowledges by zeroing
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= '0;
                else if (h_hit) q[i] <= h_wdata;
                else if (c_hit) q[i] <= '0;
            end
        end else if (KIND == ENTRY_C2H) begin : g_c2h
            // Controller stores the message; a host write acknowledges by zeroing
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= '0;
                else if (c_hit) q[i] <= c_wdata;
                else if (h_hit) q[i] <= '0;
            end
        end else begin : g_shared
            // Plain storage, host has priority on a collision
            always_ff @(posedge clk) begin
                if (!rst_n)     q[i] <= '0;
                else if (h_hit) q[i] <= h_wdata;
                else if (c_hit) q[i] <= c_wdata;
            end
        end
    end

    // R5
    h2c_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && c_addr == AW'(H2C_IDX) && !(h_we && h_addr == AW'(H2C_IDX)))
        |=> (q[H2C_IDX] == '0));

    // R8
    c2h_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == AW'(C2H_IDX) && !(c_we && c_addr == AW'(C2H_IDX)))
        |=> (q[C2H_IDX] == '0));

    // R10
    host_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && c_we && h_addr == c_addr && h_addr > AW'(C2H_IDX))
        |=> (q[$past(h_addr)] == $past(h_wdata)));

endmodule

// File: rtl/mbox_flag.sv
// Module: mbox_flag
// A sticky pending event with a maskable level output. A set in the same
// cycle as a clear wins. Masking hides the event but keeps it pending.
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic en,
    output logic pend,
    output logic irq
);

    // Pending bit: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (set_ev) pend <= 1'b1;
        else if (clr_ev) pend <= 1'b0;
    end

    // Level output gated by the enable
    always_comb irq = pend & en;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> pend);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !set_ev) |=> !pend);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && !clr_ev) |=> $stable(pend));

endmodule

// File: rtl/mbox_rdport.sv
// Module: mbox_rdport
// Registered read path for one port. Captures the addressed entry on the
// strobe and holds the value otherwise. Assumes the bank is stable until the edge.
module mbox_rdport #(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned AW         = $clog2(NUM_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd,
    input  logic [AW-1:0]                       addr,
    input  logic [NUM_ENTRIES-1:0][DATA_W-1:0]  bank,
    output logic [DATA_W-1:0]                   rdata
);

    // Capture the addressed entry on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= bank[addr];
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/mbox_regfile.sv
// Module: mbox_regfile (top)
// A dual-port mailbox bank with two interrupting message entries. Decodes the
// message events from both ports and ties together the storage, the two read
// paths and the two pending flags. Assumes both ports share one clock.
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned AW         = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              h_wr,
    input  logic              h_rd,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [AW-1:0]     c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic              c_wr,
    input  logic              c_rd,
    output logic [DATA_W-1:0] c_rdata,
    input  logic              c_irq_en,
    input  logic              h_smi_en,
    output logic              c_irq,
    output logic              h_smi
);

    logic [NUM_ENTRIES-1:0][DATA_W-1:0] bank;
    logic h2c_set, h2c_clr, c2h_set, c2h_clr;
    logic h2c_pend, c2h_pend;

    // Message events decoded from the port strobes
    always_comb begin
        h2c_set = h_wr && (h_addr == AW'(H2C_IDX));
        h2c_clr = c_rd && (c_addr == AW'(H2C_IDX));
        c2h_set = c_wr && (c_addr == AW'(C2H_IDX));
        c2h_clr = h_rd && (h_addr == AW'(C2H_IDX));
    end

    mbox_store #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (h_wr),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .c_we    (c_wr),
        .c_addr  (c_addr),
        .c_wdata (c_wdata),
        .q       (bank)
    );

    mbox_rdport #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_host_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (h_rd),
        .addr  (h_addr),
        .bank  (bank),
        .rdata (h_rdata)
    );

    mbox_rdport #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_ctrl_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (c_rd),
        .addr  (c_addr),
        .bank  (bank),
        .rdata (c_rdata)
    );

    mbox_flag u_h2c_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (h2c_set),
        .clr_ev (h2c_clr),
        .en     (c_irq_en),
        .pend   (h2c_pend),
        .irq    (c_irq)
    );

    mbox_flag u_c2h_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (c2h_set),
        .clr_ev (c2h_clr),
        .en     (h_smi_en),
        .pend   (c2h_pend),
        .irq    (h_smi)
    );

    // R3
    h2c_write_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h2c_set && c_irq_en) |=> (c_irq || !c_irq_en));

    // R11
    h2c_unrelated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h2c_set && !h2c_clr) |=> (h2c_pend == $past(h2c_pend)));

    // R11
    c2h_unrelated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c2h_set && !c2h_clr) |=> (c2h_pend == $past(c2h_pend)));

endmodule

// File: tb/tb_mbox_regfile.sv
// Self-checking bench for mbox_regfile: directed corner cases plus seeded
// random traffic, compared each cycle against a model built from the requirements.
module tb_mbox_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] h_addr = '0, c_addr = '0;
    logic [7:0] h_wdata = '0, c_wdata = '0;
    logic       h_wr = 1'b0, h_rd = 1'b0, c_wr = 1'b0, c_rd = 1'b0;
    logic       c_irq_en = 1'b0, h_smi_en = 1'b0;
    logic [7:0] h_rdata, c_rdata;
    logic       c_irq, h_smi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] m_mem [32];
    logic [7:0] m_hrd, m_crd;
    bit         m_pc, m_ph;

    always #5 clk = ~clk;

    mbox_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr), .h_rd(h_rd), .h_rdata(h_rdata),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_wr(c_wr), .c_rd(c_rd), .c_rdata(c_rdata),
        .c_irq_en(c_irq_en), .h_smi_en(h_smi_en), .c_irq(c_irq), .h_smi(h_smi)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic chk_all();
        chk("R2 host rdata", h_rdata, m_hrd);
        chk("R2 ctrl rdata", c_rdata, m_crd);
        chk("R3 c_irq", {7'd0, c_irq}, {7'd0, m_pc & c_irq_en});
        chk("R6 h_smi", {7'd0, h_smi}, {7'd0, m_ph & h_smi_en});
    endtask

    // One clock of stimulus, starting and ending at a falling edge
    task automatic cycle(input bit hw, input logic [4:0] ha, input logic [7:0] hd, input bit hr,
                         input bit cw, input logic [4:0] ca, input logic [7:0] cd, input bit cr);
        h_wr = hw; h_addr = ha; h_wdata = hd; h_rd = hr;
        c_wr = cw; c_addr = ca; c_wdata = cd; c_rd = cr;
        if (hr) m_hrd = m_mem[ha];
        if (cr) m_crd = m_mem[ca];
        if (hw && ha == 0)      m_pc = 1'b1;
        else if (cr && ca == 0) m_pc = 1'b0;
        if (cw && ca == 1)      m_ph = 1'b1;
        else if (hr && ha == 1) m_ph = 1'b0;
        if (hw && ha == 1) m_mem[1] = 8'h00;
        if (cw) m_mem[ca] = (ca == 0) ? 8'h00 : cd;
        if (hw && ha != 1) m_mem[ha] = hd;
        @(posedge clk);
        @(negedge clk);
        h_wr = 1'b0; h_rd = 1'b0; c_wr = 1'b0; c_rd = 1'b0;
        chk_all();
    endtask

    task automatic idle();
        cycle(0, 5'd0, 8'd0, 0, 0, 5'd0, 8'd0, 0);
    endtask

    function automatic logic [4:0] pick_addr();
        if ($urandom_range(0, 3) == 0) return 5'($urandom_range(0, 31));
        return 5'($urandom_range(0, 2));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        m_hrd = 8'h00; m_crd = 8'h00; m_pc = 1'b0; m_ph = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c_irq_en = 1'b1; h_smi_en = 1'b1;

        // R1: reset state of outputs and every entry
        chk("R1 c_irq", {7'd0, c_irq}, 8'd0);
        chk("R1 h_smi", {7'd0, h_smi}, 8'd0);
        chk("R1 h_rdata", h_rdata, 8'd0);
        for (int i = 0; i < 32; i++) begin
            cycle(0, 5'(i), 8'd0, 1, 0, 5'(31 - i), 8'd0, 1);
            chk("R1 entry", h_rdata, 8'h00);
        end

        // R3 / R4: host message raises, controller read clears
        cycle(1, 5'd0, 8'hA5, 0, 0, 5'd0, 8'd0, 0);
        chk("R3 irq raised", {7'd0, c_irq}, 8'd1);
        cycle(0, 5'd0, 8'd0, 0, 0, 5'd0, 8'd0, 1);
        chk("R4 read data", c_rdata, 8'hA5);
        chk("R4 cleared", {7'd0, c_irq}, 8'd0);
        // R4: set wins over same-cycle clear
        cycle(1, 5'd0, 8'h3C, 0, 0, 5'd0, 8'd0, 0);
        cycle(1, 5'd0, 8'h5A, 0, 0, 5'd0, 8'd0, 1);
        chk("R4 set wins", {7'd0, c_irq}, 8'd1);
        chk("R2 old value", c_rdata, 8'h3C);
        // R5: controller acknowledge zeroes, pending kept
        cycle(0, 5'd0, 8'd0, 0, 1, 5'd0, 8'hFF, 0);
        cycle(0, 5'd0, 8'd0, 1, 0, 5'd0, 8'd0, 0);
        chk("R5 ack zero", h_rdata, 8'h00);
        chk("R5 pend kept", {7'd0, c_irq}, 8'd1);
        cycle(1, 5'd0, 8'h66, 0, 1, 5'd0, 8'h11, 0);
        cycle(0, 5'd0, 8'd0, 1, 0, 5'd0, 8'd0, 1);
        chk("R5 host wins", h_rdata, 8'h66);

        // R6 / R7 / R8: controller message toward the host
        cycle(0, 5'd0, 8'd0, 0, 1, 5'd1, 8'hC3, 0);
        chk("R6 smi raised", {7'd0, h_smi}, 8'd1);
        cycle(0, 5'd1, 8'd0, 1, 1, 5'd1, 8'h44, 0);
        chk("R7 set wins", {7'd0, h_smi}, 8'd1);
        chk("R7 old value", h_rdata, 8'hC3);
        cycle(1, 5'd1, 8'h99, 0, 0, 5'd0, 8'd0, 0);
        cycle(0, 5'd0, 8'd0, 0, 0, 5'd1, 8'd0, 1);
        chk("R8 ack zero", c_rdata, 8'h00);
        chk("R8 pend kept", {7'd0, h_smi}, 8'd1);
        cycle(1, 5'd1, 8'h12, 0, 1, 5'd1, 8'h34, 0);
        cycle(0, 5'd1, 8'd0, 1, 0, 5'd0, 8'd0, 0);
        chk("R8 ctrl wins", h_rdata, 8'h34);
        chk("R7 cleared", {7'd0, h_smi}, 8'd0);

        // R9: masking keeps the event
        cycle(0, 5'd0, 8'd0, 0, 0, 5'd0, 8'd0, 1);
        c_irq_en = 1'b0;
        cycle(1, 5'd0, 8'h01, 0, 0, 5'd0, 8'd0, 0);
        chk("R9 masked", {7'd0, c_irq}, 8'd0);
        idle();
        c_irq_en = 1'b1;
        #1 chk("R9 unmasked", {7'd0, c_irq}, 8'd1);

        // R11: unrelated accesses leave pending events alone
        cycle(0, 5'd1, 8'd0, 0, 1, 5'd1, 8'h07, 0);
        cycle(1, 5'd5, 8'h55, 1, 1, 5'd6, 8'h66, 1);
        cycle(0, 5'd0, 8'd0, 1, 0, 5'd1, 8'd0, 1);
        chk("R11 c_irq kept", {7'd0, c_irq}, 8'd1);
        chk("R11 h_smi kept", {7'd0, h_smi}, 8'd1);

        // R10: shared entries, collision and parallel writes
        cycle(1, 5'd7, 8'hAA, 0, 1, 5'd7, 8'hBB, 0);
        cycle(0, 5'd5, 8'd0, 1, 0, 5'd7, 8'd0, 1);
        chk("R10 host priority", c_rdata, 8'hAA);
        chk("R10 parallel host", h_rdata, 8'h55);
        cycle(0, 5'd6, 8'd0, 1, 0, 5'd31, 8'd0, 0);
        chk("R10 parallel ctrl", h_rdata, 8'h66);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) c_irq_en = ~c_irq_en;
            if ($urandom_range(0, 15) == 0) h_smi_en = ~h_smi_en;
            cycle(1'($urandom_range(0, 1)), pick_addr(), 8'($urandom), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), pick_addr(), 8'($urandom), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule